// File: doc/BRIEF.md
# Oversampling Serial Receiver with Address-Mark Mute

This block receives asynchronous serial characters on one data line. A strobe at sixteen times the bit rate drives it. A falling edge starts a start-bit qualification over a fixed set of samples. When the start bit is accepted, the block recovers 8 or 9 data bits, least significant first, by majority vote over three mid-bit samples. It then checks the stop bit. A finished character moves into a one-deep data register together with its noise, framing and parity status.

The data register is a stream output. `rx_valid_o` is the valid signal and `rd_ready_i` is the ready signal, and a transfer happens on any cycle where both are high. The line itself cannot be stalled. If a character completes while the register still holds an untaken one, the new character is dropped and the overrun flag is raised. A character that completes in the same cycle as a transfer is stored, and no overrun is raised.

For multi-drop buses the receiver has a mute state with two wake methods. In idle-line wake, software mutes the receiver and a full frame time of idle line unmutes it. In address-mark wake, address characters mute or unmute the receiver in hardware, depending on whether their low nibble matches a programmed station address. While muted, the receiver discards characters and their status.

Top module: `uart_mute_rx`

## Requirements
- R1: After reset, `rx_valid_o`, `mute_o` and all four status flags are 0.
- R2: An 8-bit character sent LSB first appears on `rx_data_o[7:0]` with `rx_data_o[8]`=0, and `rx_valid_o`=1.
- R3: With `cfg_nine_i`=1, nine data bits are received and the ninth lands in `rx_data_o[8]`.
- R4: A start bit is accepted only if, counting the first low sample after three high samples as sample 1, samples 3, 5, 7, 8, 9 and 10 are also low. A failed start raises no flag and loads nothing. The receiver then waits for a new high-to-low transition.
- R5: A transfer (`rx_valid_o` and `rd_ready_i` both 1) clears `rx_valid_o` and all status flags. The flags are never 1 while `rx_valid_o` is 0.
- R6: A character that completes while `rx_valid_o`=1 and no transfer happens sets `ovr_err_o`. The data register keeps its old contents.
- R7: Each bit takes the majority of its samples 8, 9 and 10. If those three samples disagree in any bit, `noise_err_o` is set for that character.
- R8: `frame_err_o` is set when the stop-bit majority is 0. The character is still loaded.
- R9: With `cfg_par_en_i`=1, the top data bit (bit 7, or bit 8 when nine bits are used) is parity. `par_err_o` is set when the count of ones over all data bits is odd with `cfg_par_odd_i`=0, or even with `cfg_par_odd_i`=1.
- R10: With `cfg_wake_addr_i`=1, a character whose top data bit is 1 is an address. If `rx_data[3:0]` differs from `cfg_addr_i`, the receiver mutes with no load. If it matches, the receiver unmutes and the address character is loaded. Non-address characters are discarded while muted.
- R11: With `cfg_wake_addr_i`=0, software mutes the receiver and characters are discarded. A continuous high line lasting one frame time (10 bit times, or 11 with nine bits) clears `mute_o`.
- R12: A write on `rwu_wr_i` loads `rwu_wdata_i` into `mute_o` only when `rx_valid_o`=0. Otherwise the write is ignored.
- R13: A character that completes in the same cycle as a transfer is loaded, `rx_valid_o` stays 1, and `ovr_err_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | One-cycle strobe at 16x the bit rate |
| cfg_nine_i | input | 1 | 1 selects nine data bits |
| cfg_par_en_i | input | 1 | Parity checking enable |
| cfg_par_odd_i | input | 1 | 1 selects odd parity |
| cfg_wake_addr_i | input | 1 | 1 selects address-mark wake, 0 selects idle-line wake |
| cfg_addr_i | input | ADDR_W | Station address |
| rd_ready_i | input | 1 | Ready of the data stream |
| rwu_wr_i | input | 1 | Software write strobe for the mute bit |
| rwu_wdata_i | input | 1 | Value written to the mute bit |
| rx_data_o | output | 9 | Received character |
| rx_valid_o | output | 1 | Data register full (stream valid) |
| ovr_err_o | output | 1 | Overrun flag |
| noise_err_o | output | 1 | Noise flag |
| frame_err_o | output | 1 | Framing flag |
| par_err_o | output | 1 | Parity flag |
| mute_o | output | 1 | Receiver muted |

## Verification
The main collision is a stream transfer and a character completion landing on the same clock cycle. This is where draining and loading meet, and overrun must not be raised. The bench knows which 16x strobe samples the stop bit, because it generates the strobes itself. It raises `rd_ready_i` for exactly the following cycle while an older character is still pending. It then expects the new value in the register, valid still high, and no overrun. A second pairing is a software mute write against a full data register. That write must lose, and the bench judges it by `mute_o` right after the write.

// File: rtl/uart_mute_rx_pkg.sv
package uart_mute_rx_pkg;
  localparam int unsigned DW       = 9;      // widest character
  localparam int unsigned SMP_W    = 4;      // 16 samples per bit
  localparam logic [3:0]  SMP_A    = 4'd7;   // sample 8
  localparam logic [3:0]  SMP_B    = 4'd8;   // sample 9
  localparam logic [3:0]  SMP_C    = 4'd9;   // sample 10, vote point
  localparam logic [3:0]  SMP_LAST = 4'd15;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  // start-bit sample numbers (0-based from the edge) that must read low
  function automatic logic start_probe(input logic [3:0] n);
    return (n == 4'd2) || (n == 4'd4) || (n == 4'd6) ||
           (n == 4'd7) || (n == 4'd8) || (n == 4'd9);
  endfunction

  // ticks of continuous high line making one idle frame
  function automatic logic [7:0] idle_limit(input logic nine);
    return nine ? 8'd176 : 8'd160;
  endfunction
endpackage

// File: rtl/uart_mute_rx_frame.sv
module uart_mute_rx_frame
  import uart_mute_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          nine_i,
  output logic          rx_s_o,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] word_o,
  output logic          noise_o,
  output logic          ferr_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  rx_state_e              st;
  logic [SMP_W-1:0]       cnt;
  logic [SMP_W-1:0]       nxt;
  logic [3:0]             bidx;
  logic [3:0]             last_bit;
  logic [2:0]             hist;
  logic [DW-1:0]          shreg;
  logic                   v_a, v_b, noise_acc;
  logic                   rx_s, maj, split;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
  end

  assign rx_s     = sync_q[SYNC_STAGES-1];
  assign rx_s_o   = rx_s;
  assign idle_o   = (st == ST_IDLE);
  assign nxt      = cnt + 4'd1;
  assign last_bit = nine_i ? 4'd8 : 4'd7;
  assign maj      = (v_a & v_b) | (v_a & rx_s) | (v_b & rx_s);
  assign split    = !((v_a == v_b) && (v_b == rx_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; bidx <= '0; hist <= '0; shreg <= '0;
      v_a <= 1'b0; v_b <= 1'b0; noise_acc <= 1'b0;
      done_o <= 1'b0; word_o <= '0; noise_o <= 1'b0; ferr_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        cnt <= nxt;
        unique case (st)
          ST_IDLE: begin
            hist <= {hist[1:0], rx_s};
            if (hist == 3'b111 && !rx_s) begin
              st <= ST_START; cnt <= '0; bidx <= '0;
              shreg <= '0; noise_acc <= 1'b0;
            end
          end
          ST_START: begin
            if (rx_s && start_probe(nxt)) begin
              st <= ST_IDLE; hist <= '0;      // silent abort
            end else if (nxt == SMP_LAST) begin
              st <= ST_DATA;
            end
          end
          ST_DATA: begin
            if (nxt == SMP_A) v_a <= rx_s;
            if (nxt == SMP_B) v_b <= rx_s;
            if (nxt == SMP_C) begin
              shreg[bidx] <= maj;
              if (split) noise_acc <= 1'b1;
            end
            if (nxt == SMP_LAST) begin
              bidx <= bidx + 4'd1;
              if (bidx == last_bit) st <= ST_STOP;
            end
          end
          ST_STOP: begin
            if (nxt == SMP_A) v_a <= rx_s;
            if (nxt == SMP_B) v_b <= rx_s;
            if (nxt == SMP_C) begin
              done_o  <= 1'b1;
              word_o  <= shreg;
              noise_o <= noise_acc | split;
              ferr_o  <= !maj;
              hist    <= maj ? 3'b111 : 3'b000;
              st      <= ST_IDLE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_mute_rx_idle.sv
module uart_mute_rx_idle
  import uart_mute_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic rx_s_i,
  input  logic line_idle_i,
  input  logic nine_i,
  output logic pulse_o
);
  logic [7:0] cnt;
  logic [7:0] limit;

  assign limit = idle_limit(nine_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (!line_idle_i || !rx_s_i) begin
        cnt <= '0;
      end else if (tick_i && cnt < limit) begin
        cnt <= cnt + 8'd1;
        if (cnt == limit - 8'd1) pulse_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_mute_rx_wake.sv
module uart_mute_rx_wake (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  input  logic addr_mode_i,
  input  logic is_addr_i,
  input  logic match_i,
  input  logic idle_pulse_i,
  input  logic sw_wr_i,
  input  logic sw_data_i,
  input  logic full_i,
  output logic mute_o,
  output logic accept_o
);
  logic addr_char;

  assign addr_char = addr_mode_i && is_addr_i;
  assign accept_o  = addr_char ? match_i : !mute_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           mute_o <= 1'b0;
    else if (done_i && addr_char)         mute_o <= !match_i;
    else if (idle_pulse_i && !addr_mode_i) mute_o <= 1'b0;
    else if (sw_wr_i && !full_i)          mute_o <= sw_data_i;
  end
endmodule

// File: rtl/uart_mute_rx.sv
module uart_mute_rx
  import uart_mute_rx_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic              cfg_nine_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_wake_addr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic              rd_ready_i,
  input  logic              rwu_wr_i,
  input  logic              rwu_wdata_i,
  output logic [DW-1:0]     rx_data_o,
  output logic              rx_valid_o,
  output logic              ovr_err_o,
  output logic              noise_err_o,
  output logic              frame_err_o,
  output logic              par_err_o,
  output logic              mute_o
);
  logic          rx_s, line_idle, frm_done, frm_noise, frm_ferr;
  logic [DW-1:0] frm_word;
  logic          idle_pulse, accept, is_addr, match, load_ev, rd_fire, par_bad;

  uart_mute_rx_frame #(.SYNC_STAGES(SYNC_STAGES)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick16_i),
    .nine_i(cfg_nine_i), .rx_s_o(rx_s), .idle_o(line_idle),
    .done_o(frm_done), .word_o(frm_word), .noise_o(frm_noise), .ferr_o(frm_ferr)
  );

  uart_mute_rx_idle u_idle (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .rx_s_i(rx_s),
    .line_idle_i(line_idle), .nine_i(cfg_nine_i), .pulse_o(idle_pulse)
  );

  assign is_addr = cfg_nine_i ? frm_word[8] : frm_word[7];
  assign match   = (frm_word[ADDR_W-1:0] == cfg_addr_i);
  assign par_bad = cfg_par_en_i && ((^frm_word) ^ cfg_par_odd_i);

  uart_mute_rx_wake u_wake (
    .clk(clk), .rst_n(rst_n), .done_i(frm_done), .addr_mode_i(cfg_wake_addr_i),
    .is_addr_i(is_addr), .match_i(match), .idle_pulse_i(idle_pulse),
    .sw_wr_i(rwu_wr_i), .sw_data_i(rwu_wdata_i), .full_i(rx_valid_o),
    .mute_o(mute_o), .accept_o(accept)
  );

  assign load_ev = frm_done && accept;
  assign rd_fire = rx_valid_o && rd_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data_o <= '0; rx_valid_o <= 1'b0; ovr_err_o <= 1'b0;
      noise_err_o <= 1'b0; frame_err_o <= 1'b0; par_err_o <= 1'b0;
    end else if (load_ev && (!rx_valid_o || rd_fire)) begin
      rx_data_o   <= frm_word;
      rx_valid_o  <= 1'b1;
      ovr_err_o   <= 1'b0;
      noise_err_o <= frm_noise;
      frame_err_o <= frm_ferr;
      par_err_o   <= par_bad;
    end else if (load_ev) begin
      ovr_err_o   <= 1'b1;
    end else if (rd_fire) begin
      rx_valid_o  <= 1'b0;
      ovr_err_o   <= 1'b0;
      noise_err_o <= 1'b0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_mute_rx_chk.sv
module uart_mute_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_ready_i,
  input logic       rwu_wr_i,
  input logic       cfg_wake_addr_i,
  input logic [8:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       ovr_err_o,
  input logic       noise_err_o,
  input logic       frame_err_o,
  input logic       par_err_o,
  input logic       mute_o,
  input logic       frm_done,
  input logic       load_ev,
  input logic       is_addr,
  input logic       match,
  input logic       idle_pulse
);
  AST_FLAGS_NEED_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_o |-> !(ovr_err_o || noise_err_o || frame_err_o || par_err_o)); // R5

  AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && rd_ready_i && !load_ev |=> !rx_valid_o); // R5

  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rd_ready_i && load_ev |=> ovr_err_o && $stable(rx_data_o)); // R6

  AST_ADDR_MISS_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && cfg_wake_addr_i && is_addr && !match && !rx_valid_o
      |=> mute_o && !rx_valid_o); // R10

  AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse && !cfg_wake_addr_i |=> !mute_o); // R11

  AST_RWU_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    rwu_wr_i && rx_valid_o && !frm_done && !idle_pulse |=> $stable(mute_o)); // R12

  AST_SAME_CYCLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && rd_ready_i && load_ev |=> rx_valid_o && !ovr_err_o); // R13
endmodule

bind uart_mute_rx uart_mute_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_ready_i(rd_ready_i), .rwu_wr_i(rwu_wr_i),
  .cfg_wake_addr_i(cfg_wake_addr_i), .rx_data_o(rx_data_o),
  .rx_valid_o(rx_valid_o), .ovr_err_o(ovr_err_o), .noise_err_o(noise_err_o),
  .frame_err_o(frame_err_o), .par_err_o(par_err_o), .mute_o(mute_o),
  .frm_done(frm_done), .load_ev(load_ev), .is_addr(is_addr), .match(match),
  .idle_pulse(idle_pulse)
);

// File: tb/tb_uart_mute_rx.sv
module tb_uart_mute_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1, tick = 1'b0;
  logic       nine = 1'b0, par_en = 1'b0, par_odd = 1'b0, wake_addr = 1'b0;
  logic [3:0] addr = 4'h5;
  logic       rd_ready = 1'b0, rwu_wr = 1'b0, rwu_wdata = 1'b0;
  logic [8:0] rdata;
  logic       valid, ovr, nf, fe, pe, mute;
  int         errors = 0, checks = 0;

  always #2 clk = ~clk;   // 250 MHz

  uart_mute_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
    .cfg_nine_i(nine), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
    .cfg_wake_addr_i(wake_addr), .cfg_addr_i(addr), .rd_ready_i(rd_ready),
    .rwu_wr_i(rwu_wr), .rwu_wdata_i(rwu_wdata), .rx_data_o(rdata),
    .rx_valid_o(valid), .ovr_err_o(ovr), .noise_err_o(nf), .frame_err_o(fe),
    .par_err_o(pe), .mute_o(mute)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one 16x strobe; line value set three cycles ahead of the strobe edge
  task automatic tick1(input logic v);
    @(negedge clk) rx = v; tick = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick1(1'b1);
  endtask

  task automatic send(input logic [8:0] w, input int nb, input logic stop,
                      input int noisy_bit, input bit rd_at_stop);
    for (int t = 0; t < 16; t++) tick1(1'b0);
    for (int b = 0; b < nb; b++)
      for (int t = 0; t < 16; t++) tick1(w[b] ^ (b == noisy_bit && t == 8));
    for (int t = 0; t < 16; t++) begin
      tick1(stop);
      if (t == 9 && rd_at_stop) begin
        rd_ready = 1'b1;
        @(negedge clk) rd_ready = 1'b0;
      end
    end
    idle(20);
  endtask

  task automatic do_read();
    @(negedge clk) rd_ready = 1'b1;
    @(negedge clk) rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic rwu(input logic v);
    @(negedge clk) rwu_wr = 1'b1; rwu_wdata = v;
    @(negedge clk) rwu_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 valid", valid, 0);
    chk("R1 flags", {ovr, nf, fe, pe}, 0);
    chk("R1 mute", mute, 0);
  endtask

  task automatic t_basic();
    send(9'h0A5, 8, 1'b1, -1, 0);
    chk("R2 data", rdata, 9'h0A5);
    chk("R2 valid", valid, 1);
    chk("R2 flags", {ovr, nf, fe, pe}, 0);
    do_read();
    chk("R5 valid cleared", valid, 0);
  endtask

  task automatic t_nine();
    nine = 1'b1;
    send(9'h1C3, 9, 1'b1, -1, 0);
    chk("R3 data", rdata, 9'h1C3);
    do_read();
    nine = 1'b0;
  endtask

  task automatic t_start_reject();
    for (int t = 0; t < 4; t++) tick1(1'b0);
    idle(30);
    chk("R4 no load", valid, 0);
    chk("R4 no flag", {ovr, nf, fe, pe}, 0);
    send(9'h03C, 8, 1'b1, -1, 0);
    chk("R4 recovers", rdata, 9'h03C);
    do_read();
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 1'b1, -1, 0);
    send(9'h022, 8, 1'b1, -1, 0);
    chk("R6 ovr", ovr, 1);
    chk("R6 old data", rdata, 9'h011);
    do_read();
    chk("R5 ovr cleared", ovr, 0);
  endtask

  task automatic t_noise();
    send(9'h05A, 8, 1'b1, 3, 0);
    chk("R7 nf", nf, 1);
    chk("R7 majority data", rdata, 9'h05A);
    do_read();
  endtask

  task automatic t_frame();
    send(9'h077, 8, 1'b0, -1, 0);
    chk("R8 fe", fe, 1);
    chk("R8 loaded", valid, 1);
    do_read();
    chk("R5 fe cleared", fe, 0);
  endtask

  task automatic t_parity();
    par_en = 1'b1;
    send(9'h003, 8, 1'b1, -1, 0);
    chk("R9 even ok", pe, 0);
    do_read();
    send(9'h083, 8, 1'b1, -1, 0);
    chk("R9 even bad", pe, 1);
    do_read();
    par_odd = 1'b1;
    send(9'h083, 8, 1'b1, -1, 0);
    chk("R9 odd ok", pe, 0);
    do_read();
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_addr();
    wake_addr = 1'b1;
    send(9'h083, 8, 1'b1, -1, 0);
    chk("R10 miss mutes", mute, 1);
    chk("R10 miss no load", valid, 0);
    send(9'h042, 8, 1'b1, -1, 0);
    chk("R10 muted data dropped", valid, 0);
    send(9'h085, 8, 1'b1, -1, 0);
    chk("R10 hit unmutes", mute, 0);
    chk("R10 hit loaded", rdata, 9'h085);
    do_read();
    send(9'h042, 8, 1'b1, -1, 0);
    chk("R10 data after wake", rdata, 9'h042);
    do_read();
    wake_addr = 1'b0;
  endtask

  task automatic t_idle_wake();
    rwu(1'b1);
    chk("R11 sw mute", mute, 1);
    send(9'h055, 8, 1'b1, -1, 0);
    chk("R11 dropped", valid, 0);
    chk("R11 still muted", mute, 1);
    idle(180);
    chk("R11 idle wake", mute, 0);
    send(9'h066, 8, 1'b1, -1, 0);
    chk("R11 after wake", rdata, 9'h066);
    do_read();
  endtask

  task automatic t_rwu_ignore();
    send(9'h012, 8, 1'b1, -1, 0);
    rwu(1'b1);
    chk("R12 write ignored", mute, 0);
    do_read();
    rwu(1'b1);
    chk("R12 write taken", mute, 1);
    rwu(1'b0);
    chk("R12 write cleared", mute, 0);
  endtask

  task automatic t_same_cycle();
    send(9'h033, 8, 1'b1, -1, 0);
    send(9'h044, 8, 1'b1, -1, 1);
    chk("R13 new data", rdata, 9'h044);
    chk("R13 valid", valid, 1);
    chk("R13 no ovr", ovr, 0);
    do_read();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    idle(30);
    t_basic();
    t_nine();
    t_start_reject();
    t_overrun();
    t_noise();
    t_frame();
    t_parity();
    t_addr();
    t_idle_wake();
    t_rwu_ignore();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule